// File: doc/BRIEF.md
# Serial Receive Deframer with Format Checking

The block turns an asynchronous serial input into bytes. A 16x oversampling tick drives it. It first synchronises the line. It then finds the falling edge of a start bit, confirms that bit at its centre and samples every later bit at its centre. Eight data bits arrive least significant bit first. They may be followed by one extra bit, which is either a parity bit or an address flag. One stop bit follows.

Each finished character is written into a receive store together with three flags: extra-bit error, framing error and break. The store works in one of two modes. As a queue it holds up to `DEPTH` entries. As a single holding slot it keeps one character. A consumer reads through a byte-wide port. The port shows the oldest entry with a valid flag, and a one-cycle read strobe removes that entry.

The format inputs decide how the extra bit is treated. The bit can be absent, it can carry odd or even parity, it can be forced to a fixed value, or it can act as a 9th data bit that marks an address.

Top module: `uart_rx_checker`

## Requirements
- R1: After reset `rd_valid` and `overrun` are 0, and the line idle level (1) produces no entry.
- R2: A frame is a 0 start bit, then 8 data bits sent least significant bit first, then an optional extra bit, then a stop bit of 1. It is stored with `rd_data` equal to the byte and all three flags 0. Each bit lasts 16 `os_tick` pulses.
- R3: A low pulse on `rxd` that is gone by the centre of the start bit (8 ticks after the edge) is rejected, and no entry is produced.
- R4: With `nine_bit`=0, `par_en`=1 and `par_stick`=0, one extra bit follows the data. `rd_par_err` is set when the parity of the data and the extra bit together is odd while `par_even`=1. It is also set when that parity is even while `par_even`=0.
- R5: With `nine_bit`=0, `par_en`=1 and `par_stick`=1, the extra bit must equal the inverse of `par_even`. So `par_even`=0 expects 1 and `par_even`=1 expects 0. Any other value sets `rd_par_err`.
- R6: With `nine_bit`=0 and `par_en`=0, no extra bit is expected. The bit after the data is the stop bit, and `rd_par_err` stays 0.
- R7: With `nine_bit`=1, one extra bit follows the data whatever the parity inputs are. `rd_par_err` equals that bit and serves as the address-received flag.
- R8: Only the first stop bit is examined. After it the receiver immediately looks for a new start bit, so frames sent with one or with two stop bits are both accepted.
- R9: A stop bit sampled 0 sets `rd_frm_err` for that character. The receiver then waits for `rxd`=1 before it looks for a new start.
- R10: A frame in which every sampled bit is 0 (data, any extra bit, and the stop bit) stores exactly one entry with data 0, `rd_brk`=1, `rd_frm_err`=1 and `rd_par_err`=0. No further entry appears while the line stays low.
- R11: With `fifo_mode`=0 one character is held. A character that completes while that slot is occupied is discarded, `overrun` goes to 1, and the held character is kept.
- R12: With `fifo_mode`=1 up to `DEPTH` characters are returned in arrival order. A character that arrives when the store is full is discarded, sets `overrun`, and leaves the stored ones unchanged.
- R13: Changing `fifo_mode` empties the store and clears `overrun`.
- R14: `rd_en`=1 while `rd_valid`=1 removes the head entry one cycle later, and the same removal clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial input, idle high |
| par_en | input | 1 | Extra parity bit present and checked |
| par_even | input | 1 | Even parity, or stick value select |
| par_stick | input | 1 | Parity bit forced to a fixed level |
| nine_bit | input | 1 | Extra bit is an address flag |
| fifo_mode | input | 1 | 1 = queue of DEPTH entries, 0 = single slot |
| rd_en | input | 1 | Remove head entry |
| rd_valid | output | 1 | Head entry present |
| rd_data | output | 8 | Head entry data byte |
| rd_par_err | output | 1 | Head entry parity error or address flag |
| rd_frm_err | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry is a break |
| overrun | output | 1 | A character was dropped since the last read |

## Verification
The bench builds the block with `DEPTH`=4. With that size, filling the queue and forcing an overrun takes only five frames, so the queue-mode discard path runs next to the single-slot path within a short run. The oversampling rate stays at 16 and `os_tick` pulses every second clock. Bit centres therefore fall on a divided tick, which tests sampling under an enable and not on every clock.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic par_en;
        logic par_even;
        logic par_stick;
        logic nine_bit;
    } fmt_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_EXTRA,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    function automatic logic fmt_has_extra(fmt_cfg_t c);
        return c.nine_bit | c.par_en;
    endfunction

    function automatic logic fmt_extra_err(fmt_cfg_t c, logic [BYTE_W-1:0] d, logic b);
        logic err;
        if (c.nine_bit)
            err = b;
        else if (!c.par_en)
            err = 1'b0;
        else if (c.par_stick)
            err = (b == c.par_even);
        else if (c.par_even)
            err = (b != ^d);
        else
            err = (b == ^d);
        return err;
    endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else
            chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/urx_deframer.sv
module urx_deframer
    import urx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  fmt_cfg_t  cfg,
    output logic      push,
    output rx_entry_t entry
);
    localparam int CW = $clog2(OS_RATE);
    localparam logic [CW-1:0] MID_CNT  = CW'(OS_RATE/2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OS_RATE - 1);

    rx_state_t         state;
    logic [CW-1:0]     os_cnt;
    logic [2:0]        bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              extra_b;
    logic              all_low;

    assign all_low = !rxd && (shreg == '0) && (!fmt_has_extra(cfg) || !extra_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            extra_b <= 1'b0;
            push    <= 1'b0;
            entry   <= '0;
        end else begin
            push <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    os_cnt <= '0;
                    if (tick && !rxd)
                        state <= ST_START;
                end
                ST_START: if (tick) begin
                    if (os_cnt == MID_CNT) begin
                        os_cnt  <= '0;
                        bit_idx <= '0;
                        extra_b <= 1'b0;
                        state   <= rxd ? ST_IDLE : ST_DATA;
                    end else begin
                        os_cnt <= os_cnt + 1'b1;
                    end
                end
                ST_DATA: if (tick) begin
                    if (os_cnt == LAST_CNT) begin
                        os_cnt <= '0;
                        shreg  <= {rxd, shreg[BYTE_W-1:1]};
                        if (bit_idx == 3'd7)
                            state <= fmt_has_extra(cfg) ? ST_EXTRA : ST_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end else begin
                        os_cnt <= os_cnt + 1'b1;
                    end
                end
                ST_EXTRA: if (tick) begin
                    if (os_cnt == LAST_CNT) begin
                        os_cnt  <= '0;
                        extra_b <= rxd;
                        state   <= ST_STOP;
                    end else begin
                        os_cnt <= os_cnt + 1'b1;
                    end
                end
                ST_STOP: if (tick) begin
                    if (os_cnt == LAST_CNT) begin
                        os_cnt     <= '0;
                        push       <= 1'b1;
                        entry.data <= all_low ? '0 : shreg;
                        entry.perr <= all_low ? 1'b0 : fmt_extra_err(cfg, shreg, extra_b);
                        entry.ferr <= !rxd;
                        entry.brk  <= all_low;
                        state      <= rxd ? ST_IDLE : ST_HOLD;
                    end else begin
                        os_cnt <= os_cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (rxd)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: a start edge not confirmed at mid-bit returns to idle
    a_r3_start_reject: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick && os_cnt == MID_CNT && rxd) |=> state == ST_IDLE);

    // R10: break entry carries zero data and a framing error
    a_r10_brk_zero: assert property (@(posedge clk) disable iff (rst)
        (push && entry.brk) |-> (entry.data == '0 && entry.ferr && !entry.perr));

    // R9: a stop sampled low keeps the receiver parked while the line stays low
    a_r9_hold_low: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !rxd) |=> state == ST_HOLD);

    // R8: one write per frame, immediately ready for a new start
    a_r8_single_push: assert property (@(posedge clk) disable iff (rst)
        push |-> (state == ST_IDLE || state == ST_HOLD) && $past(state) == ST_STOP);
endmodule

// File: rtl/urx_store.sv
module urx_store
    import urx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fifo_mode,
    input  logic      push,
    input  rx_entry_t wr_entry,
    input  logic      rd_en,
    output logic      rd_valid,
    output rx_entry_t rd_entry,
    output logic      overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [NW-1:0] count, cap;
    logic          mode_q, flush, full, pop, wr_ok;

    assign cap      = fifo_mode ? NW'(DEPTH) : NW'(1);
    assign full     = (count >= cap);
    assign flush    = (fifo_mode != mode_q);
    assign pop      = rd_en && (count != '0) && !flush;
    assign wr_ok    = push && !full && !flush;
    assign rd_valid = (count != '0);
    assign rd_entry = mem[rptr];

    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[wptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
            mode_q  <= fifo_mode;
        end else begin
            mode_q <= fifo_mode;
            if (flush) begin
                wptr    <= '0;
                rptr    <= '0;
                count   <= '0;
                overrun <= 1'b0;
            end else begin
                if (wr_ok)
                    wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
                if (pop)
                    rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
                if (wr_ok && !pop)
                    count <= count + 1'b1;
                else if (pop && !wr_ok)
                    count <= count - 1'b1;
                if (push && full)
                    overrun <= 1'b1;
                else if (pop)
                    overrun <= 1'b0;
            end
        end
    end

    // R12: occupancy never exceeds the queue size
    a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= NW'(DEPTH));

    // R11: single-slot mode never holds more than one entry
    a_r11_single_slot: assert property (@(posedge clk) disable iff (rst)
        (!fifo_mode && !flush) |-> count <= NW'(1));

    // R11/R12: a discarded write leaves the head entry untouched
    a_r12_keep_head: assert property (@(posedge clk) disable iff (rst)
        (push && full && !rd_en && !flush) |=> $stable(rd_entry));

    // R14: overrun only rises on a write into a full store
    a_r14_ovr_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(push && full));
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker
    import urx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             os_tick,
    input  logic             rxd,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             par_stick,
    input  logic             nine_bit,
    input  logic             fifo_mode,
    input  logic             rd_en,
    output logic             rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic             rd_par_err,
    output logic             rd_frm_err,
    output logic             rd_brk,
    output logic             overrun
);
    logic      rxd_s;
    logic      push;
    fmt_cfg_t  cfg;
    rx_entry_t new_entry, head;

    assign cfg = '{par_en: par_en, par_even: par_even,
                   par_stick: par_stick, nine_bit: nine_bit};

    urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rxd_s)
    );

    urx_deframer #(.OS_RATE(OS_RATE)) u_deframer (
        .clk   (clk),
        .rst   (rst),
        .tick  (os_tick),
        .rxd   (rxd_s),
        .cfg   (cfg),
        .push  (push),
        .entry (new_entry)
    );

    urx_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .fifo_mode (fifo_mode),
        .push      (push),
        .wr_entry  (new_entry),
        .rd_en     (rd_en),
        .rd_valid  (rd_valid),
        .rd_entry  (head),
        .overrun   (overrun)
    );

    assign rd_data    = head.data;
    assign rd_par_err = head.perr;
    assign rd_frm_err = head.ferr;
    assign rd_brk     = head.brk;
endmodule

// File: tb/uart_rx_checker_tb.sv
module uart_rx_checker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int BIT_CLKS   = 32;

    logic clk = 1'b0, rst = 1'b1, os_tick = 1'b0, rxd = 1'b1;
    logic par_en = 0, par_even = 0, par_stick = 0, nine_bit = 0, fifo_mode = 1, rd_en = 0;
    logic rd_valid, rd_par_err, rd_frm_err, rd_brk, overrun;
    logic [7:0] rd_data;
    int tests = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;

    uart_rx_checker #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .nine_bit(nine_bit), .fifo_mode(fifo_mode), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_par_err(rd_par_err),
        .rd_frm_err(rd_frm_err), .rd_brk(rd_brk), .overrun(overrun)
    );

    function automatic logic exp_perr(logic pe, logic ev, logic st, logic nb,
                                      logic [7:0] d, logic xb);
        if (nb) return xb;
        if (!pe) return 1'b0;
        if (st) return xb != !ev;
        return (^{d, xb}) == ev;
    endfunction

    task automatic line_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic xb, input logic stop1,
                              input int nstop, input int idle_bits);
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        if (nine_bit || par_en) line_bit(xb);
        line_bit(stop1);
        for (int i = 1; i < nstop; i++) line_bit(1'b1);
        for (int i = 0; i < idle_bits; i++) line_bit(1'b1);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_head(input string req, input logic [7:0] d, input logic p,
                             input logic f, input logic b);
        check(req, {20'd0, rd_valid, rd_data, rd_par_err, rd_frm_err, rd_brk},
                   {20'd0, 1'b1, d, p, f, b});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_fmt(input logic pe, input logic ev, input logic st, input logic nb);
        par_en = pe; par_even = ev; par_stick = st; nine_bit = nb;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state and quiet idle line
        check("R1 valid", {31'd0, rd_valid}, 0);
        check("R1 overrun", {31'd0, overrun}, 0);
        line_bit(1'b1); line_bit(1'b1);
        check("R1 idle no entry", {31'd0, rd_valid}, 0);

        // R2: 8N1 frames
        set_fmt(0, 0, 0, 0);
        send_frame(8'hA5, 0, 1, 1, 1);
        read_head("R2 A5", 8'hA5, 0, 0, 0);
        send_frame(8'h01, 0, 1, 1, 1);
        read_head("R2 01", 8'h01, 0, 0, 0);

        // R3: short glitch rejected
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        line_bit(1'b1); line_bit(1'b1);
        check("R3 glitch", {31'd0, rd_valid}, 0);

        // R4: odd and even parity, good and bad
        set_fmt(1, 0, 0, 0);
        send_frame(8'h03, 1'b1, 1, 1, 1);
        read_head("R4 odd ok", 8'h03, 0, 0, 0);
        send_frame(8'h03, 1'b0, 1, 1, 1);
        read_head("R4 odd bad", 8'h03, 1, 0, 0);
        set_fmt(1, 1, 0, 0);
        send_frame(8'h07, 1'b1, 1, 1, 1);
        read_head("R4 even ok", 8'h07, 0, 0, 0);
        send_frame(8'h07, 1'b0, 1, 1, 1);
        read_head("R4 even bad", 8'h07, 1, 0, 0);

        // R5: stick parity
        set_fmt(1, 0, 1, 0);
        send_frame(8'h00, 1'b1, 1, 1, 1);
        read_head("R5 stick1 ok", 8'h00, 0, 0, 0);
        send_frame(8'h55, 1'b0, 1, 1, 1);
        read_head("R5 stick1 bad", 8'h55, 1, 0, 0);
        set_fmt(1, 1, 1, 0);
        send_frame(8'hFF, 1'b0, 1, 1, 1);
        read_head("R5 stick0 ok", 8'hFF, 0, 0, 0);
        send_frame(8'hFF, 1'b1, 1, 1, 1);
        read_head("R5 stick0 bad", 8'hFF, 1, 0, 0);

        // R6: parity off, odd-weight data, no extra bit
        set_fmt(0, 1, 1, 0);
        send_frame(8'h01, 0, 1, 1, 1);
        read_head("R6 no parity", 8'h01, 0, 0, 0);

        // R7: address bit
        set_fmt(1, 1, 0, 1);
        send_frame(8'h3C, 1'b1, 1, 1, 1);
        read_head("R7 address", 8'h3C, 1, 0, 0);
        send_frame(8'h3D, 1'b0, 1, 1, 1);
        read_head("R7 data", 8'h3D, 0, 0, 0);

        // R8: one stop bit sent with no idle, then a two-stop frame
        set_fmt(0, 0, 0, 0);
        send_frame(8'h11, 0, 1, 1, 0);
        send_frame(8'h22, 0, 1, 2, 1);
        read_head("R8 first", 8'h11, 0, 0, 0);
        read_head("R8 second", 8'h22, 0, 0, 0);

        // R9: framing error
        send_frame(8'h5A, 0, 0, 1, 2);
        read_head("R9 framing", 8'h5A, 0, 1, 0);

        // R10: long break gives one entry
        set_fmt(1, 0, 0, 0);
        for (int i = 0; i < 16; i++) line_bit(1'b0);
        line_bit(1'b1); line_bit(1'b1);
        read_head("R10 break", 8'h00, 0, 1, 1);
        check("R10 single entry", {31'd0, rd_valid}, 0);

        // R12: queue order and overrun
        set_fmt(0, 0, 0, 0);
        for (int i = 0; i < DEPTH + 1; i++) send_frame(8'h40 + 8'(i), 0, 1, 1, 1);
        check("R12 overrun", {31'd0, overrun}, 1);
        for (int i = 0; i < DEPTH; i++) begin
            read_head("R12 order", 8'h40 + 8'(i), 0, 0, 0);
            if (i == 0) check("R14 overrun cleared", {31'd0, overrun}, 0);
        end
        check("R12 drained", {31'd0, rd_valid}, 0);

        // R13: mode switch flushes
        send_frame(8'h77, 0, 1, 1, 1);
        fifo_mode = 1'b0;
        repeat (3) @(negedge clk);
        check("R13 flushed", {31'd0, rd_valid}, 0);

        // R11: single slot
        send_frame(8'h81, 0, 1, 1, 1);
        send_frame(8'h82, 0, 1, 1, 1);
        check("R11 overrun", {31'd0, overrun}, 1);
        read_head("R11 kept first", 8'h81, 0, 0, 0);
        check("R11 one only", {31'd0, rd_valid}, 0);
        fifo_mode = 1'b1;
        repeat (3) @(negedge clk);

        // random frames against the reference flags
        for (int n = 0; n < 30; n++) begin
            logic [7:0] d;
            logic xb, st1, bk, has_x;
            int ns;
            set_fmt(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            d   = ((n % 7) == 3) ? 8'h00 : 8'($urandom);
            xb  = 1'($urandom);
            st1 = ($urandom % 4) != 0;
            ns  = 1 + ($urandom % 2);
            has_x = par_en || nine_bit;
            bk  = !st1 && (d == 8'h00) && (!has_x || !xb);
            send_frame(d, xb, st1, ns, 1);
            read_head(bk ? "R10 random" : (st1 ? "R4 random" : "R9 random"), d,
                      bk ? 1'b0 : exp_perr(par_en, par_even, par_stick, nine_bit, d, xb),
                      !st1, bk);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule